// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block brings one switchable power domain up and down. It drives a five-bit control word and an external buck isolation line. It watches a primary and a secondary power-acknowledge input. Two external helpers take part in each sequence: one handles the SRAM power handshake and one handles bus protection. The block talks to each helper through a request/direction/done/error port.

A power request arrives on a valid/ready pair. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request offered while the block is busy is dropped, not queued, so the requester must hold `req_valid` until it sees ready. Each accepted request runs to the end and finishes with a one-cycle `done` pulse or a one-cycle `error` pulse.

The block performs at most one control action per clock. Both acknowledge waits are bounded by a cycle-count timeout. A failing helper during power-up unwinds the steps already taken, in reverse order, before the error is reported.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, `pwr_ctl` = 5'b10010 and `buck_iso` = 1. The control word bits are: bit0 active-low domain reset, bit1 isolation, bit2 main switch enable, bit3 secondary switch enable, bit4 clock disable. At the same time `busy`, `done`, `error`, `sram_req` and `bp_req` are 0 and `req_ready` is 1.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high, and `busy` is high in the cycle after acceptance. A `req_valid` pulse while busy has no effect: the running sequence, its control changes and its single completion pulse are unchanged, and no second sequence follows.
- R3: A power-up request (`req_on`=1) performs these steps in order: clear buck isolation, set main enable, set secondary enable, wait for both acknowledges, clear clock disable, clear isolation, release reset, SRAM handshake with `sram_en`=1, bus-protection handshake with `bp_release`=1. It then pulses `done`.
- R4: The domain counts as powered only when both synchronized acknowledges are high. Clock disable is never cleared unless both acknowledge inputs are high.
- R5: A power-down request (`req_on`=0) performs these steps in order: bus-protection handshake with `bp_release`=0, SRAM handshake with `sram_en`=0, set buck isolation, set isolation, set clock disable, assert reset, clear secondary enable, clear main enable, wait for both acknowledges low. It then pulses `done`.
- R6: `buck_iso` is cleared before the main enable rises on power-up. It is set again after the SRAM is disabled on power-down. With HAS_BUCK_ISO=0 it stays 0.
- R7: An acknowledge wait that lasts ACK_TIMEOUT cycles without reaching its target ends the sequence with `error`. The control outputs keep the values they had when the wait began.
- R8: If the SRAM handshake fails during power-up, the block sets buck isolation, then isolation, then clock disable. It then asserts reset, clears the secondary enable and clears the main enable, and pulses `error`. It does not wait for the acknowledges.
- R9: If the bus-protection release fails during power-up, the block first re-engages bus protection and then disables the SRAM. It then performs the R8 control unwind and pulses `error`. Results returned by unwind handshakes are ignored.
- R10: If a handshake fails during power-down, the sequence stops there with `error`, and no control bit changes.
- R11: At most one bit of {`buck_iso`, `pwr_ctl`} changes per clock. A helper request stays high until that helper returns done or error.
- R12: `done` and `error` are one-cycle pulses, never high together, and appear in the first cycle in which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Power request valid |
| req_on | input | 1 | Requested state: 1 = power up, 0 = power down |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| ack_main | input | 1 | Primary power acknowledge (asynchronous) |
| ack_sec | input | 1 | Secondary power acknowledge (asynchronous) |
| pwr_ctl | output | 5 | Control word (bit layout in R1) |
| buck_iso | output | 1 | External buck isolation |
| sram_req | output | 1 | SRAM helper request |
| sram_en | output | 1 | SRAM direction: 1 = enable, 0 = disable |
| sram_done | input | 1 | SRAM helper finished |
| sram_err | input | 1 | SRAM helper failed |
| bp_req | output | 1 | Bus-protection helper request |
| bp_release | output | 1 | Bus-protection direction: 1 = release, 0 = engage |
| bp_done | input | 1 | Bus-protection helper finished |
| bp_err | input | 1 | Bus-protection helper failed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |

## Verification
The hardest path to reach is the bus-protection failure at the very end of power-up. Reaching it needs every earlier step to succeed, and then the unwind must be seen re-engaging protection and turning the SRAM off before the control bits fall. The bench's helper models fail only requests of a chosen direction, so a failed release is followed by a successful re-engage. Stuck-high and stuck-low acknowledge models produce the timeouts in both directions. Randomized helper latencies, acknowledge delays and fault choices then drive sequences that start from whatever state the last failure left behind.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int CTL_W      = 5;
  localparam int BIT_RSTN   = 0;
  localparam int BIT_ISO    = 1;
  localparam int BIT_MAIN   = 2;
  localparam int BIT_SEC    = 3;
  localparam int BIT_CLKDIS = 4;

  // Domain held off: clock disabled, isolated, reset asserted, switches open.
  localparam logic [CTL_W-1:0] CTL_OFF = 5'b10010;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_U_BUCK, ST_U_MAIN, ST_U_SEC, ST_U_ACK, ST_U_CLK, ST_U_ISO, ST_U_RST,
    ST_U_SRAM_GO, ST_U_SRAM_W, ST_U_BP_GO, ST_U_BP_W,
    ST_D_BP_GO, ST_D_BP_W, ST_D_SRAM_GO, ST_D_SRAM_W,
    ST_D_BUCK, ST_D_ISO, ST_D_CLK, ST_D_RST, ST_D_SEC, ST_D_MAIN, ST_D_ACK,
    ST_R_BP_GO, ST_R_BP_W, ST_R_SRAM_GO, ST_R_SRAM_W
  } seq_state_t;
endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_stage[g-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r7_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pds_hs_port.sv
module pds_hs_port (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_dir,
  input  logic sub_done,
  input  logic sub_err,
  output logic req,
  output logic dir,
  output logic ok,
  output logic fail
);
  logic req_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (start) begin
      req_q <= 1'b1;
      dir_q <= start_dir;
    end else if (req_q && (sub_done || sub_err)) begin
      req_q <= 1'b0;
    end
  end

  assign req  = req_q;
  assign dir  = dir_q;
  assign ok   = req_q && sub_done;
  assign fail = req_q && sub_err && !sub_done;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !sub_done && !sub_err) |=> req_q);
  a_r11_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !start) |=> (dir_q == $past(dir_q)));
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int ACK_TIMEOUT  = 64,
  parameter int SYNC_STAGES  = 2,
  parameter int HAS_BUCK_ISO = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_on,
  output logic             req_ready,
  input  logic             ack_main,
  input  logic             ack_sec,
  output logic [CTL_W-1:0] pwr_ctl,
  output logic             buck_iso,
  output logic             sram_req,
  output logic             sram_en,
  input  logic             sram_done,
  input  logic             sram_err,
  output logic             bp_req,
  output logic             bp_release,
  input  logic             bp_done,
  input  logic             bp_err,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam logic BUCK_RST = (HAS_BUCK_ISO != 0);

  seq_state_t       st;
  logic [CTL_W-1:0] ctl_q;
  logic             buck_q, unwind_q, done_q, err_q;

  // acknowledge synchronizer
  logic [1:0] ack_s;
  logic       all_on, all_off;

  pds_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d({ack_sec, ack_main}), .q(ack_s)
  );
  assign all_on  = &ack_s;
  assign all_off = ~|ack_s;

  // acknowledge timeout
  logic tmr_run, tmr_exp;
  assign tmr_run = (st == ST_U_ACK) || (st == ST_D_ACK);

  pds_timer #(.LIMIT(ACK_TIMEOUT)) u_ack_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_exp)
  );

  // helper handshake ports
  logic sram_start, sram_start_dir, sram_ok, sram_fail;
  logic bp_start, bp_start_dir, bp_ok, bp_fail;

  assign sram_start     = (st == ST_U_SRAM_GO) || (st == ST_D_SRAM_GO) || (st == ST_R_SRAM_GO);
  assign sram_start_dir = (st == ST_U_SRAM_GO);
  assign bp_start       = (st == ST_U_BP_GO) || (st == ST_D_BP_GO) || (st == ST_R_BP_GO);
  assign bp_start_dir   = (st == ST_U_BP_GO);

  pds_hs_port u_sram_port (
    .clk(clk), .rst_n(rst_n), .start(sram_start), .start_dir(sram_start_dir),
    .sub_done(sram_done), .sub_err(sram_err),
    .req(sram_req), .dir(sram_en), .ok(sram_ok), .fail(sram_fail)
  );

  pds_hs_port u_bp_port (
    .clk(clk), .rst_n(rst_n), .start(bp_start), .start_dir(bp_start_dir),
    .sub_done(bp_done), .sub_err(bp_err),
    .req(bp_req), .dir(bp_release), .ok(bp_ok), .fail(bp_fail)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ctl_q    <= CTL_OFF;
      buck_q   <= BUCK_RST;
      unwind_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          unwind_q <= 1'b0;
          st       <= req_on ? ST_U_BUCK : ST_D_BP_GO;
        end
        // power-up
        ST_U_BUCK: begin
          if (HAS_BUCK_ISO != 0) buck_q <= 1'b0;
          st <= ST_U_MAIN;
        end
        ST_U_MAIN: begin ctl_q[BIT_MAIN] <= 1'b1; st <= ST_U_SEC; end
        ST_U_SEC:  begin ctl_q[BIT_SEC]  <= 1'b1; st <= ST_U_ACK; end
        ST_U_ACK: begin
          if (all_on) st <= ST_U_CLK;
          else if (tmr_exp) begin st <= ST_IDLE; err_q <= 1'b1; end
        end
        ST_U_CLK: begin ctl_q[BIT_CLKDIS] <= 1'b0; st <= ST_U_ISO; end
        ST_U_ISO: begin ctl_q[BIT_ISO]    <= 1'b0; st <= ST_U_RST; end
        ST_U_RST: begin ctl_q[BIT_RSTN]   <= 1'b1; st <= ST_U_SRAM_GO; end
        ST_U_SRAM_GO: st <= ST_U_SRAM_W;
        ST_U_SRAM_W: begin
          if (sram_ok) st <= ST_U_BP_GO;
          else if (sram_fail) begin unwind_q <= 1'b1; st <= ST_D_BUCK; end
        end
        ST_U_BP_GO: st <= ST_U_BP_W;
        ST_U_BP_W: begin
          if (bp_ok) begin st <= ST_IDLE; done_q <= 1'b1; end
          else if (bp_fail) st <= ST_R_BP_GO;
        end
        // unwind of a failed bus-protection release
        ST_R_BP_GO: st <= ST_R_BP_W;
        ST_R_BP_W:  if (bp_ok || bp_fail) st <= ST_R_SRAM_GO;
        ST_R_SRAM_GO: st <= ST_R_SRAM_W;
        ST_R_SRAM_W: if (sram_ok || sram_fail) begin
          unwind_q <= 1'b1;
          st       <= ST_D_BUCK;
        end
        // power-down
        ST_D_BP_GO: st <= ST_D_BP_W;
        ST_D_BP_W: begin
          if (bp_ok) st <= ST_D_SRAM_GO;
          else if (bp_fail) begin st <= ST_IDLE; err_q <= 1'b1; end
        end
        ST_D_SRAM_GO: st <= ST_D_SRAM_W;
        ST_D_SRAM_W: begin
          if (sram_ok) st <= ST_D_BUCK;
          else if (sram_fail) begin st <= ST_IDLE; err_q <= 1'b1; end
        end
        ST_D_BUCK: begin
          if (HAS_BUCK_ISO != 0) buck_q <= 1'b1;
          st <= ST_D_ISO;
        end
        ST_D_ISO: begin ctl_q[BIT_ISO]    <= 1'b1; st <= ST_D_CLK; end
        ST_D_CLK: begin ctl_q[BIT_CLKDIS] <= 1'b1; st <= ST_D_RST; end
        ST_D_RST: begin ctl_q[BIT_RSTN]   <= 1'b0; st <= ST_D_SEC; end
        ST_D_SEC: begin ctl_q[BIT_SEC]    <= 1'b0; st <= ST_D_MAIN; end
        ST_D_MAIN: begin
          ctl_q[BIT_MAIN] <= 1'b0;
          if (unwind_q) begin st <= ST_IDLE; err_q <= 1'b1; end
          else st <= ST_D_ACK;
        end
        ST_D_ACK: begin
          if (all_off) begin st <= ST_IDLE; done_q <= 1'b1; end
          else if (tmr_exp) begin st <= ST_IDLE; err_q <= 1'b1; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pwr_ctl   = ctl_q;
  assign buck_iso  = buck_q;
  assign busy      = (st != ST_IDLE);
  assign req_ready = !busy;
  assign done      = done_q;
  assign error     = err_q;

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  a_r4_clk_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[BIT_CLKDIS]) |-> $past(all_on, 2));
  a_r6_buck_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[BIT_MAIN]) |-> (!buck_q || HAS_BUCK_ISO == 0));
  a_r11_one_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({buck_q, ctl_q} ^ $past({buck_q, ctl_q})) <= 1);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || err_q) |=> !(done_q || err_q));
  a_r12_idle_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || err_q) |-> !busy);
endmodule

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
  localparam int TO = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_on, req_ready;
  logic ack_main, ack_sec;
  logic [4:0] pwr_ctl;
  logic buck_iso, sram_req, sram_en, sram_done, sram_err;
  logic bp_req, bp_release, bp_done, bp_err;
  logic busy, done, error;

  always #5 clk = ~clk;

  pwr_domain_seq #(.ACK_TIMEOUT(TO), .SYNC_STAGES(2), .HAS_BUCK_ISO(1)) u_pwr_domain_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on), .req_ready(req_ready),
    .ack_main(ack_main), .ack_sec(ack_sec), .pwr_ctl(pwr_ctl), .buck_iso(buck_iso),
    .sram_req(sram_req), .sram_en(sram_en), .sram_done(sram_done), .sram_err(sram_err),
    .bp_req(bp_req), .bp_release(bp_release), .bp_done(bp_done), .bp_err(bp_err),
    .busy(busy), .done(done), .error(error)
  );

  // acknowledge models: delayed copies of the switch enables, optionally stuck
  logic [7:0] shm = '0, shs = '0;
  int  dlym = 1, dlys = 1;
  bit  stuck_m = 0, stuck_s = 0;
  bit  stuckv_m = 0, stuckv_s = 0;
  always @(posedge clk) begin
    shm <= {shm[6:0], pwr_ctl[2]};
    shs <= {shs[6:0], pwr_ctl[3]};
  end
  assign ack_main = stuck_m ? stuckv_m : shm[dlym];
  assign ack_sec  = stuck_s ? stuckv_s : shs[dlys];

  // helper models: fail requests of a chosen direction
  int sram_lat = 1, bp_lat = 1, sram_cnt = 0, bp_cnt = 0;
  bit fail_sram_en = 0, fail_sram_dis = 0, fail_bp_rel = 0, fail_bp_eng = 0;
  initial begin sram_done = 0; sram_err = 0; bp_done = 0; bp_err = 0; end
  always @(posedge clk) begin
    sram_done <= 1'b0; sram_err <= 1'b0;
    if (sram_req && !sram_done && !sram_err) begin
      if (sram_cnt >= sram_lat) begin
        sram_cnt <= 0;
        if ((sram_en && fail_sram_en) || (!sram_en && fail_sram_dis)) sram_err <= 1'b1;
        else sram_done <= 1'b1;
      end else sram_cnt <= sram_cnt + 1;
    end else sram_cnt <= 0;
  end
  always @(posedge clk) begin
    bp_done <= 1'b0; bp_err <= 1'b0;
    if (bp_req && !bp_done && !bp_err) begin
      if (bp_cnt >= bp_lat) begin
        bp_cnt <= 0;
        if ((bp_release && fail_bp_rel) || (!bp_release && fail_bp_eng)) bp_err <= 1'b1;
        else bp_done <= 1'b1;
      end else bp_cnt <= bp_cnt + 1;
    end else bp_cnt <= 0;
  end

  // event monitor. Codes: control bit b to value v = 2*b+v, buck = 10+v,
  // SRAM enable 12, SRAM disable 13, bus release 14, bus engage 15
  int ev_q[$];
  int mon_r11_bad = 0, mon_r4_bad = 0, nchg;
  logic [4:0] prev_ctl = 5'b10010;
  logic prev_buck = 1'b1, prev_sreq = 1'b0, prev_breq = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      nchg = 0;
      for (int b = 0; b < 5; b++) begin
        if (pwr_ctl[b] != prev_ctl[b]) begin
          ev_q.push_back(b * 2 + int'(pwr_ctl[b]));
          nchg++;
          if (b == 4 && !pwr_ctl[b] && !(ack_main && ack_sec)) mon_r4_bad++;
        end
      end
      if (buck_iso != prev_buck) begin ev_q.push_back(10 + int'(buck_iso)); nchg++; end
      if (nchg > 1) mon_r11_bad++;
      if (sram_req && !prev_sreq) ev_q.push_back(sram_en ? 12 : 13);
      if (bp_req && !prev_breq) ev_q.push_back(bp_release ? 14 : 15);
    end
    prev_ctl = pwr_ctl; prev_buck = buck_iso; prev_sreq = sram_req; prev_breq = bp_req;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected model
  logic [4:0] m_ctl;
  logic m_buck;
  int exp_q[$];
  task automatic xc(int b, logic v);
    if (m_ctl[b] != v) begin exp_q.push_back(b * 2 + int'(v)); m_ctl[b] = v; end
  endtask
  task automatic xb(logic v);
    if (m_buck != v) begin exp_q.push_back(10 + int'(v)); m_buck = v; end
  endtask
  task automatic x_down_ctl();
    xb(1'b1); xc(1, 1'b1); xc(4, 1'b1); xc(0, 1'b0); xc(3, 1'b0); xc(2, 1'b0);
  endtask
  // fault for power-up: 0 none, 1 ack timeout, 2 SRAM fail, 3 bus release fail
  // fault for power-down: 0 none, 1 bus engage fail, 2 SRAM fail, 3 ack timeout
  task automatic build_exp(bit on, int f);
    exp_q.delete();
    if (on) begin
      xb(1'b0); xc(2, 1'b1); xc(3, 1'b1);
      if (f == 1) return;
      xc(4, 1'b0); xc(1, 1'b0); xc(0, 1'b1);
      exp_q.push_back(12);
      if (f == 2) begin x_down_ctl(); return; end
      exp_q.push_back(14);
      if (f == 3) begin exp_q.push_back(15); exp_q.push_back(13); x_down_ctl(); end
    end else begin
      exp_q.push_back(15);
      if (f == 1) return;
      exp_q.push_back(13);
      if (f == 2) return;
      x_down_ctl();
    end
  endtask

  function automatic string tag_of(bit on, int f);
    if (on) return (f == 0) ? "R3" : (f == 1) ? "R7" : (f == 2) ? "R8" : "R9";
    return (f == 0) ? "R5" : (f == 3) ? "R7" : "R10";
  endfunction

  task automatic run_txn(bit on, int f, bit poke);
    int base, cyc;
    string tg;
    bit saw_done, saw_err;
    tg = tag_of(on, f);
    dlym = $urandom % 7; dlys = $urandom % 7;
    sram_lat = $urandom % 5; bp_lat = $urandom % 5;
    if (on && f == 1) begin stuck_s = 1; stuckv_s = 0; end
    if (on && f == 2) fail_sram_en = 1;
    if (on && f == 3) fail_bp_rel = 1;
    if (!on && f == 1) fail_bp_eng = 1;
    if (!on && f == 2) fail_sram_dis = 1;
    if (!on && f == 3) begin stuck_m = 1; stuckv_m = 1; end
    build_exp(on, f);
    base = ev_q.size();
    @(negedge clk); req_valid = 1; req_on = on;
    @(negedge clk); req_valid = 0;
    chk(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
    if (poke) begin
      req_valid = 1; req_on = !on;
      @(negedge clk); req_valid = 0;
    end
    cyc = 0;
    while (!(done || error) && cyc < 3000) begin @(negedge clk); cyc++; end
    saw_done = done; saw_err = error;
    chk(saw_done == (f == 0) && saw_err == (f != 0), tg, "done/error",
        int'({saw_done, saw_err}), (f == 0) ? 2 : 1);
    chk(busy == 1'b0, "R12", "busy with completion pulse", int'(busy), 0);
    if ((on && f == 1) || (!on && f == 3))
      chk(cyc >= TO, "R7", "cycles before timeout", cyc, TO);
    @(negedge clk);
    chk(done == 1'b0 && error == 1'b0, "R12", "pulse width", int'({done, error}), 0);
    chk(ev_q.size() - base == exp_q.size(), tg, "event count", ev_q.size() - base, exp_q.size());
    for (int i = 0; i < exp_q.size() && base + i < ev_q.size(); i++)
      chk(ev_q[base + i] == exp_q[i], tg, $sformatf("event %0d", i), ev_q[base + i], exp_q[i]);
    chk(pwr_ctl == m_ctl, tg, "final control word", int'(pwr_ctl), int'(m_ctl));
    if (f == 0)
      chk(buck_iso == !on, "R6", "buck isolation", int'(buck_iso), int'(!on));
    if (on && f == 0)
      chk(ack_main && ack_sec, "R4", "acks at power-up end", int'({ack_main, ack_sec}), 3);
    stuck_m = 0; stuck_s = 0;
    fail_sram_en = 0; fail_sram_dis = 0; fail_bp_rel = 0; fail_bp_eng = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (poke && busy) chk(1'b0, "R2", "ignored request started", 1, 0);
    end
    if (poke) chk(busy == 1'b0 && req_ready == 1'b1, "R2", "idle after poke", int'(busy), 0);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5EED);
    rst_n = 0; req_valid = 0; req_on = 0;
    m_ctl = 5'b10010; m_buck = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pwr_ctl == 5'b10010, "R1", "reset control word", int'(pwr_ctl), 18);
    chk(buck_iso == 1'b1, "R1", "reset buck isolation", int'(buck_iso), 1);
    chk({busy, done, error} == 3'b000, "R1", "reset status", int'({busy, done, error}), 0);
    chk({sram_req, bp_req} == 2'b00, "R1", "reset helper requests", int'({sram_req, bp_req}), 0);
    chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
    // directed corners
    run_txn(1, 0, 0);
    run_txn(0, 0, 1);
    run_txn(1, 0, 1);
    run_txn(1, 0, 0);
    run_txn(0, 1, 0);
    run_txn(0, 2, 0);
    run_txn(0, 0, 0);
    run_txn(1, 2, 0);
    run_txn(1, 3, 0);
    run_txn(1, 1, 0);
    run_txn(0, 0, 0);
    run_txn(1, 0, 0);
    run_txn(0, 3, 0);
    // random mix
    for (int k = 0; k < 40; k++) begin
      bit on_r;
      int f_r;
      on_r = 1'($urandom % 2);
      f_r  = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 3);
      run_txn(on_r, f_r, 1'($urandom % 2));
    end
    chk(mon_r11_bad == 0, "R11", "cycles with more than one control change", mon_r11_bad, 0);
    chk(mon_r4_bad == 0, "R4", "clock enabled without both acks", mon_r4_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end
endmodule